// File: doc/BRIEF.md
# CPU Bus Address Decoder

This block sits between a 16-bit CPU bus (24-bit byte address space, separate upper and lower data strobes, read/write line and an address strobe) and the memories and peripherals of a board. For every bus cycle it works out which device owns the address and raises one select line for it. It also gives the device's local offset after mirroring, a register index for the video processor, and per-byte write enables. Address ranges that must never answer raise a hang flag, and no acknowledge is given for them.

Some regions drive only the low byte lane. For these regions the decoder supplies the read data of the other lane itself. It returns the high byte of the prefetch word for the upper lane in the peripheral window, returns 0xFF for the sound port, and returns the whole prefetch word for a program ROM pair that is flagged absent. An odd-byte write to the sound port produces a single write pulse that carries the byte. All outputs are registered. They follow the address strobe by one clock and return to zero one clock after the strobe goes inactive.

Top module: `bus_decode_top`

## Requirements
- R1: Byte addresses 0x000000–0x0FFFFF set sel_o bit 0 and 0x100000–0x1FFFFF set sel_o bit 1. The local offset is the address modulo 1 MB.
- R2: Byte addresses 0x200000–0x7FFFFF and 0xA00000–0xBFFFFF set hang_o. They give no select, no dtack_o and no write enable.
- R3: In 0x800000–0x9FFFFF, bits 19:18 of the address pick the select: 0 is the protection/video register window (bit 2), 1 is I/O (bit 3), 2 is the sound port (bit 4) and 3 is color RAM (bit 5). 0x9xxxxx behaves exactly like 0x8xxxxx.
- R4: In 0xC00000–0xDFFFFF the video processor (sel_o bit 6) is selected only when address bits 18:16 and 7:5 are all zero. reg_idx_o then equals byte-address bits 4:0, where bit 0 is 1 only for a lower-strobe-only access. Every other address in that range sets hang_o. reg_idx_o is 0 whenever the video processor is not selected.
- R5: 0xE00000–0xFFFFFF sets sel_o bit 7 with a local offset modulo 64 KB. Color RAM gives an offset modulo 1 KB, the three other peripheral regions give an offset modulo 256 KB, and the video processor gives an offset modulo 32.
- R6: In 0x800000–0x9FFFFF, we_hi_o is never set. A read there sets ovr_hi_o, and ovr_data_o[15:8] then equals prefetch_i[15:8].
- R7: A read in the sound region sets ovr_lo_o with ovr_data_o[7:0] = 0xFF. A write there that uses the lower strobe gives snd_wr_o for exactly the first registered cycle of the bus cycle, with snd_data_o = wdata_i[7:0].
- R8: A read from ROM pair k (k = 0 or 1) while rom_absent_i[k] is 1 sets both ovr_hi_o and ovr_lo_o with ovr_data_o = prefetch_i.
- R9: The outputs show the decode of the inputs sampled at a clock edge where as_n_i is 0. After an edge where as_n_i is 1, every output is 0.
- R10: At most one sel_o bit is set. dtack_o is set exactly when some sel_o bit is set. Write enables follow the active strobes of a write to a non-hanging address, and outputs not named by a rule are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr_i | input | 23 | Word address, byte-address bits 23:1 |
| as_n_i | input | 1 | Address strobe, active low |
| uds_n_i | input | 1 | Upper data strobe, active low |
| lds_n_i | input | 1 | Lower data strobe, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| rom_absent_i | input | 2 | Per ROM pair: 1 = pair not fitted |
| prefetch_i | input | 16 | Current prefetch word |
| wdata_i | input | 16 | CPU write data |
| sel_o | output | 8 | One-hot device select |
| hang_o | output | 1 | Access to a stalling address |
| dtack_o | output | 1 | Transfer acknowledge |
| loc_o | output | 20 | Mirrored local byte offset |
| reg_idx_o | output | 5 | Video processor register index |
| we_hi_o | output | 1 | Upper byte write enable |
| we_lo_o | output | 1 | Lower byte write enable |
| ovr_hi_o | output | 1 | Upper read byte supplied by decoder |
| ovr_lo_o | output | 1 | Lower read byte supplied by decoder |
| ovr_data_o | output | 16 | Override read data |
| snd_wr_o | output | 1 | Sound message write pulse |
| snd_data_o | output | 8 | Sound message byte |

## Verification
Each decode result appears on the output one clock edge after the edge that samples the address strobe low. The bench drives inputs at a falling edge and reads every output at the next falling edge, which is half a period after the capturing edge. It holds the strobe low for a second cycle to confirm that the sound pulse has dropped while the selects stay put. Then it releases the strobe and checks one cycle later that every output has cleared.

// File: rtl/bdec_pkg.sv
package bdec_pkg;
  localparam int BUS_AW = 24;
  localparam int NSEL   = 8;

  typedef enum logic [2:0] {
    RG_ROM0 = 3'd0, RG_ROM1 = 3'd1, RG_REGW = 3'd2, RG_IO   = 3'd3,
    RG_SND  = 3'd4, RG_CRAM = 3'd5, RG_VDP  = 3'd6, RG_WRAM = 3'd7
  } region_e;

  typedef struct packed {
    logic    hang;
    logic    win;
    region_e rg;
  } dec_t;

  // video processor answers only on a sparse pattern inside its range
  function automatic logic vdp_match(input logic [BUS_AW-1:0] ba);
    return (ba[18:16] == 3'b000) && (ba[7:5] == 3'b000);
  endfunction

  function automatic dec_t decode_addr(input logic [BUS_AW-1:0] ba);
    dec_t d;
    d.hang = 1'b0;
    d.win  = 1'b0;
    d.rg   = RG_ROM0;
    case (ba[23:20])
      4'h0: d.rg = RG_ROM0;
      4'h1: d.rg = RG_ROM1;
      4'h8, 4'h9: begin
        d.win = 1'b1;
        case (ba[19:18])
          2'd0: d.rg = RG_REGW;
          2'd1: d.rg = RG_IO;
          2'd2: d.rg = RG_SND;
          default: d.rg = RG_CRAM;
        endcase
      end
      4'hC, 4'hD: begin
        d.rg   = RG_VDP;
        d.hang = !vdp_match(ba);
      end
      4'hE, 4'hF: d.rg = RG_WRAM;
      default: d.hang = 1'b1;
    endcase
    return d;
  endfunction

  // offset mask reflecting each device's mirror period
  function automatic logic [BUS_AW-1:0] loc_mask(input region_e rg);
    case (rg)
      RG_ROM0, RG_ROM1:       return 24'h0F_FFFF;
      RG_REGW, RG_IO, RG_SND: return 24'h03_FFFF;
      RG_CRAM:                return 24'h00_03FF;
      RG_VDP:                 return 24'h00_001F;
      default:                return 24'h00_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/bdec_region.sv
module bdec_region
  import bdec_pkg::*;
#(
  parameter int LOC_W = 20,
  parameter int IDX_W = 5
) (
  input  logic [BUS_AW-1:1] addr_i,
  input  logic              uds_n_i,
  input  logic              lds_n_i,
  output dec_t              dec_o,
  output logic [NSEL-1:0]   sel_o,
  output logic [LOC_W-1:0]  loc_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [BUS_AW-1:0] ba;
  logic              a0;
  logic [BUS_AW-1:0] off;

  assign ba    = {addr_i, 1'b0};
  assign a0    = uds_n_i & ~lds_n_i;
  assign dec_o = decode_addr(ba);
  assign off   = ba & loc_mask(dec_o.rg);
  assign loc_o = dec_o.hang ? '0 : off[LOC_W-1:0];

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    assign sel_o[g] = !dec_o.hang && (dec_o.rg == region_e'(g));
  end

  assign idx_o = sel_o[RG_VDP] ? IDX_W'({ba[IDX_W-1:1], a0}) : '0;
endmodule

// File: rtl/bdec_lane.sv
module bdec_lane
  import bdec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  dec_t              dec_i,
  input  logic              rw_i,
  input  logic              uds_n_i,
  input  logic              lds_n_i,
  input  logic [1:0]        rom_absent_i,
  input  logic [DATA_W-1:0] prefetch_i,
  output logic              we_hi_o,
  output logic              we_lo_o,
  output logic              ovr_hi_o,
  output logic              ovr_lo_o,
  output logic [DATA_W-1:0] ovr_data_o,
  output logic              snd_req_o
);
  localparam int BYTE_W = DATA_W / 2;

  logic wr, rd, rom_gone;

  assign wr = !rw_i && !dec_i.hang;
  assign rd =  rw_i && !dec_i.hang;
  assign rom_gone = (dec_i.rg == RG_ROM0 && rom_absent_i[0]) ||
                    (dec_i.rg == RG_ROM1 && rom_absent_i[1]);

  assign we_hi_o   = wr && !uds_n_i && !dec_i.win;
  assign we_lo_o   = wr && !lds_n_i;
  assign snd_req_o = wr && !lds_n_i && dec_i.rg == RG_SND;

  always_comb begin
    ovr_hi_o   = 1'b0;
    ovr_lo_o   = 1'b0;
    ovr_data_o = '0;
    if (rd && rom_gone) begin
      ovr_hi_o   = 1'b1;
      ovr_lo_o   = 1'b1;
      ovr_data_o = prefetch_i;
    end else if (rd && dec_i.win) begin
      ovr_hi_o = 1'b1;
      ovr_data_o[DATA_W-1:BYTE_W] = prefetch_i[DATA_W-1:BYTE_W];
      if (dec_i.rg == RG_SND) begin
        ovr_lo_o = 1'b1;
        ovr_data_o[BYTE_W-1:0] = '1;
      end
    end
  end
endmodule

// File: rtl/bdec_outreg.sv
module bdec_outreg
  import bdec_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LOC_W  = 20,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_act_i,
  input  logic [NSEL-1:0]   sel_i,
  input  logic              hang_i,
  input  logic [LOC_W-1:0]  loc_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              we_hi_i,
  input  logic              we_lo_i,
  input  logic              ovr_hi_i,
  input  logic              ovr_lo_i,
  input  logic [DATA_W-1:0] ovr_data_i,
  input  logic              snd_req_i,
  input  logic [DATA_W/2-1:0] snd_byte_i,
  output logic [NSEL-1:0]   sel_o,
  output logic              hang_o,
  output logic [LOC_W-1:0]  loc_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              we_hi_o,
  output logic              we_lo_o,
  output logic              ovr_hi_o,
  output logic              ovr_lo_o,
  output logic [DATA_W-1:0] ovr_data_o,
  output logic              snd_wr_o,
  output logic [DATA_W/2-1:0] snd_data_o,
  output logic              cyc_start_o
);
  logic as_q;

  assign cyc_start_o = as_act_i && !as_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_q       <= 1'b0;
      sel_o      <= '0;
      hang_o     <= 1'b0;
      loc_o      <= '0;
      idx_o      <= '0;
      we_hi_o    <= 1'b0;
      we_lo_o    <= 1'b0;
      ovr_hi_o   <= 1'b0;
      ovr_lo_o   <= 1'b0;
      ovr_data_o <= '0;
      snd_wr_o   <= 1'b0;
      snd_data_o <= '0;
    end else begin
      as_q       <= as_act_i;
      sel_o      <= as_act_i ? sel_i : '0;
      hang_o     <= as_act_i && hang_i;
      loc_o      <= as_act_i ? loc_i : '0;
      idx_o      <= as_act_i ? idx_i : '0;
      we_hi_o    <= as_act_i && we_hi_i;
      we_lo_o    <= as_act_i && we_lo_i;
      ovr_hi_o   <= as_act_i && ovr_hi_i;
      ovr_lo_o   <= as_act_i && ovr_lo_i;
      ovr_data_o <= as_act_i ? ovr_data_i : '0;
      snd_wr_o   <= cyc_start_o && snd_req_i;
      snd_data_o <= (cyc_start_o && snd_req_i) ? snd_byte_i : '0;
    end
  end
endmodule

// File: rtl/bus_decode_top.sv
module bus_decode_top
  import bdec_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LOC_W  = 20,
  parameter int IDX_W  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BUS_AW-1:1]   addr_i,
  input  logic                as_n_i,
  input  logic                uds_n_i,
  input  logic                lds_n_i,
  input  logic                rw_i,
  input  logic [1:0]          rom_absent_i,
  input  logic [DATA_W-1:0]   prefetch_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [NSEL-1:0]     sel_o,
  output logic                hang_o,
  output logic                dtack_o,
  output logic [LOC_W-1:0]    loc_o,
  output logic [IDX_W-1:0]    reg_idx_o,
  output logic                we_hi_o,
  output logic                we_lo_o,
  output logic                ovr_hi_o,
  output logic                ovr_lo_o,
  output logic [DATA_W-1:0]   ovr_data_o,
  output logic                snd_wr_o,
  output logic [DATA_W/2-1:0] snd_data_o
);
  dec_t              dec_c;
  logic [NSEL-1:0]   sel_c;
  logic [LOC_W-1:0]  loc_c;
  logic [IDX_W-1:0]  idx_c;
  logic              we_hi_c, we_lo_c, ovr_hi_c, ovr_lo_c, snd_req_c;
  logic [DATA_W-1:0] ovr_data_c;
  logic              cyc_start;

  bdec_region #(.LOC_W(LOC_W), .IDX_W(IDX_W)) u_region (
    .addr_i(addr_i), .uds_n_i(uds_n_i), .lds_n_i(lds_n_i),
    .dec_o(dec_c), .sel_o(sel_c), .loc_o(loc_c), .idx_o(idx_c)
  );

  bdec_lane #(.DATA_W(DATA_W)) u_lane (
    .dec_i(dec_c), .rw_i(rw_i), .uds_n_i(uds_n_i), .lds_n_i(lds_n_i),
    .rom_absent_i(rom_absent_i), .prefetch_i(prefetch_i),
    .we_hi_o(we_hi_c), .we_lo_o(we_lo_c), .ovr_hi_o(ovr_hi_c),
    .ovr_lo_o(ovr_lo_c), .ovr_data_o(ovr_data_c), .snd_req_o(snd_req_c)
  );

  bdec_outreg #(.DATA_W(DATA_W), .LOC_W(LOC_W), .IDX_W(IDX_W)) u_outreg (
    .clk(clk), .rst_n(rst_n), .as_act_i(!as_n_i),
    .sel_i(sel_c), .hang_i(dec_c.hang), .loc_i(loc_c), .idx_i(idx_c),
    .we_hi_i(we_hi_c), .we_lo_i(we_lo_c), .ovr_hi_i(ovr_hi_c),
    .ovr_lo_i(ovr_lo_c), .ovr_data_i(ovr_data_c), .snd_req_i(snd_req_c),
    .snd_byte_i(wdata_i[DATA_W/2-1:0]),
    .sel_o(sel_o), .hang_o(hang_o), .loc_o(loc_o), .idx_o(reg_idx_o),
    .we_hi_o(we_hi_o), .we_lo_o(we_lo_o), .ovr_hi_o(ovr_hi_o),
    .ovr_lo_o(ovr_lo_o), .ovr_data_o(ovr_data_o), .snd_wr_o(snd_wr_o),
    .snd_data_o(snd_data_o), .cyc_start_o(cyc_start)
  );

  assign dtack_o = |sel_o;
endmodule

// File: rtl/bdec_chk.sv
module bdec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       as_n_i,
  input logic [7:0] sel_o,
  input logic       hang_o,
  input logic       dtack_o,
  input logic [4:0] reg_idx_o,
  input logic       we_hi_o,
  input logic       we_lo_o,
  input logic       ovr_lo_o,
  input logic [15:0] ovr_data_o,
  input logic       snd_wr_o
);
  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_o));
  p_hang_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hang_o |-> (sel_o == 8'd0 && !dtack_o && !we_hi_o && !we_lo_o));
  p_idle_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(as_n_i) |-> (sel_o == 8'd0 && !hang_o));
  p_no_even_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|sel_o[5:2]) |-> !we_hi_o);
  p_snd_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snd_wr_o |=> !snd_wr_o);
  p_snd_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snd_wr_o |-> (sel_o[4] && we_lo_o));
  p_snd_ff_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o[4] && ovr_lo_o) |-> ovr_data_o[7:0] == 8'hFF);
  p_idx_only_vdp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_o[6] |-> reg_idx_o == 5'd0);
endmodule

bind bus_decode_top bdec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .as_n_i(as_n_i), .sel_o(sel_o),
  .hang_o(hang_o), .dtack_o(dtack_o), .reg_idx_o(reg_idx_o),
  .we_hi_o(we_hi_o), .we_lo_o(we_lo_o), .ovr_lo_o(ovr_lo_o),
  .ovr_data_o(ovr_data_o), .snd_wr_o(snd_wr_o)
);

// File: tb/bus_decode_top_tb.sv
module bus_decode_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:1] addr_i = '0;
  logic        as_n_i = 1'b1, uds_n_i = 1'b1, lds_n_i = 1'b1, rw_i = 1'b1;
  logic [1:0]  rom_absent_i = '0;
  logic [15:0] prefetch_i = '0, wdata_i = '0;
  logic [7:0]  sel_o;
  logic        hang_o, dtack_o, we_hi_o, we_lo_o, ovr_hi_o, ovr_lo_o, snd_wr_o;
  logic [19:0] loc_o;
  logic [4:0]  reg_idx_o;
  logic [15:0] ovr_data_o;
  logic [7:0]  snd_data_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bus_decode_top u_dut (.*);

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // region number 0..7, or -1 for stall
  function automatic int ref_region(input int ba);
    if (ba < 'h100000) return 0;
    if (ba < 'h200000) return 1;
    if (ba < 'h800000) return -1;
    if (ba < 'hA00000) return 2 + (ba % 'h100000) / 'h40000;
    if (ba < 'hC00000) return -1;
    if (ba < 'hE00000) return ((ba & 'h0700E0) == 0) ? 6 : -1;
    return 7;
  endfunction

  function automatic int ref_span(input int r);
    case (r)
      0, 1: return 'h100000;
      2, 3, 4: return 'h40000;
      5: return 1024;
      6: return 32;
      default: return 'h10000;
    endcase
  endfunction

  function automatic string ref_tag(input int r);
    case (r)
      -1: return "R2";
      0, 1: return "R1";
      2, 3, 4: return "R3";
      5, 7: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic access(input int ba, input bit rd, input int lanes,
                        input bit [1:0] absent, input bit [15:0] pf,
                        input bit [15:0] wd);
    int r;
    bit uds, lds, win;
    bit [15:0] eo;
    bit eh, el;
    string t;
    r   = ref_region(ba);
    t   = ref_tag(r);
    uds = (lanes != 2);          // lanes: 0 both, 1 upper only, 2 lower only
    lds = (lanes != 1);
    win = (r >= 2 && r <= 5);
    @(negedge clk);
    addr_i = 23'(ba >> 1); rw_i = rd; uds_n_i = !uds; lds_n_i = !lds;
    rom_absent_i = absent; prefetch_i = pf; wdata_i = wd; as_n_i = 1'b0;
    @(negedge clk);
    check(t, "sel", sel_o, (r < 0) ? 0 : (1 << r));
    check("R2", "hang", hang_o, r < 0);
    check("R10", "dtack", dtack_o, r >= 0);
    check(t, "loc", loc_o, (r < 0) ? 0 : ba % ref_span(r));
    check("R4", "idx", reg_idx_o, (r == 6) ? ((ba % 32) | (!uds && lds)) : 0);
    check("R6", "we_hi", we_hi_o, !rd && r >= 0 && uds && !win);
    check("R10", "we_lo", we_lo_o, !rd && r >= 0 && lds);
    eh = 0; el = 0; eo = 0;
    if (rd && ((r == 0 && absent[0]) || (r == 1 && absent[1]))) begin
      eh = 1; el = 1; eo = pf;
    end else if (rd && win) begin
      eh = 1; eo[15:8] = pf[15:8];
      if (r == 4) begin el = 1; eo[7:0] = 8'hFF; end
    end
    check((r < 2) ? "R8" : "R6", "ovr_hi", ovr_hi_o, eh);
    check((r < 2) ? "R8" : "R7", "ovr_lo", ovr_lo_o, el);
    check((r < 2) ? "R8" : "R7", "ovr_data",
          ovr_data_o & {{8{eh}}, {8{el}}}, eo);
    check("R7", "snd_wr", snd_wr_o, !rd && r == 4 && lds);
    if (!rd && r == 4 && lds) check("R7", "snd_data", snd_data_o, wd[7:0]);
    @(negedge clk);
    check("R7", "snd_wr second cycle", snd_wr_o, 0);
    check("R9", "sel held", sel_o, (r < 0) ? 0 : (1 << r));
    as_n_i = 1'b1;
    @(negedge clk);
    check("R9", "sel idle", sel_o, 0);
    check("R9", "hang idle", hang_o, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EC2);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "reset sel", sel_o, 0);
    check("R9", "reset hang", hang_o, 0);
    check("R9", "reset ovr", ovr_data_o, 0);
    // directed corners
    access('h000000, 1, 0, 2'b00, 16'h1234, 0);   // R1 ROM0 present
    access('h1FFFFE, 1, 0, 2'b10, 16'h4E71, 0);   // R8 ROM1 absent
    access('h0ABCDE, 1, 0, 2'b01, 16'hBEEF, 0);   // R8 ROM0 absent
    access('h200000, 1, 0, 0, 0, 0);              // R2 low edge
    access('h7FFFFE, 0, 0, 0, 0, 16'hAAAA);       // R2 high edge
    access('hA00000, 1, 0, 0, 0, 0);              // R2
    access('hBFFFFE, 0, 2, 0, 0, 0);              // R2
    access('h800000, 0, 0, 0, 0, 16'h0506);       // R6 even write blocked
    access('h8FFFFE, 1, 0, 0, 16'hC3A5, 0);       // R3 cram end
    access('h940010, 1, 0, 0, 0, 0);              // R3 mirror of I/O
    access('h880000, 1, 2, 0, 16'h7788, 0);       // R7 sound read
    access('h980002, 0, 2, 0, 0, 16'h00C4);       // R7 sound write mirror
    access('hC00000, 1, 0, 0, 0, 0);              // R4 vdp
    access('hC0001E, 0, 2, 0, 0, 0);              // R4 vdp index 1F
    access('hD8FF04, 1, 1, 0, 0, 0);              // R4 don't-care bits set
    access('hC10000, 1, 0, 0, 0, 0);              // R4 bit16 -> hang
    access('hC00020, 1, 0, 0, 0, 0);              // R4 bit5 -> hang
    access('hE00000, 0, 0, 0, 0, 0);              // R5 work RAM
    access('hFFFFFE, 1, 0, 0, 0, 0);              // R5 mirror end
    // random sweep
    for (int i = 0; i < 400; i++) begin
      int ba;
      ba = int'({$urandom_range(15, 0), 20'($urandom)}) & 'hFFFFFE;
      if (i % 5 == 0) ba = (ba & 'hD8FF1E) | 'hC00000;  // force vdp hits
      access(ba, 1'($urandom), int'($urandom_range(2, 0)), 2'($urandom),
             16'($urandom), 16'($urandom));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule